// File: doc/BRIEF.md
# EEPROM Write-Guard Controller

This block decides whether a nonvolatile write to a small serial EEPROM may go ahead. It receives decoded command strobes from the serial front end: set-enable, clear-enable, array write and status write. It also receives the target byte address, an active-low hardware write-protect pin and a busy flag from the cell programming logic. It answers with a write grant and a live status byte. The status byte holds a two-bit block-protect code, the write-enable latch and a write-in-progress flag.

The core is a three-state sequencer. `ST_IDLE` accepts commands. A write that passes every check moves it to `ST_ARM`, where the grant is raised and the block waits for the cell to report busy. The transition `ST_ARM -> ST_BURN` happens when busy rises. The block stays in `ST_BURN` while the cell programs. The transition `ST_BURN -> ST_IDLE` happens when busy falls. On that transition the enable latch is cleared and, for a status write, the new protect code is committed. The protect code comes out of reset guarding the top quarter of the array, so that identifier bytes stored there survive unless software clears the code on purpose.

Top module: `wp_guard`

## Requirements
- R1: The status byte carries write-in-progress in bit 0, the write-enable latch in bit 1 and the protect code in bits 3:2. Bits 7:4 always read zero.
- R2: After reset the protect code is 01, the enable latch and write-in-progress are 0 (status = 04h), and the grant is low.
- R3: With an address width of 8, protect code 00 guards nothing, 01 guards C0h–FFh, 10 guards 80h–FFh and 11 guards 00h–FFh. An array write to a guarded address is refused. A status write is never refused because of the protect code.
- R4: While `wp_n` is low, every array or status write is refused. The enable latch is cleared in each such cycle, and a set-enable command cannot set it.
- R5: A set-enable command sets the enable latch, and a clear-enable command clears it. Any write issued while the latch is clear is refused.
- R6: For an accepted write, the grant is high from the cycle after the request until the cycle after `cell_busy` is first seen high. Write-in-progress is set from the cycle after the request.
- R7: One cycle after `cell_busy` falls in `ST_BURN`, write-in-progress and the enable latch both read 0. For a status write, the protect code then equals the `new_bp` value captured with the request.
- R8: Pulling `wp_n` low during `ST_BURN` does not end the cycle: write-in-progress stays 1 until `cell_busy` falls.
- R9: While write-in-progress is set, write requests, set-enable and clear-enable commands have no effect: no new grant, the enable latch and the protect code are unchanged, and the status byte stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Set-enable command strobe |
| cmd_wrdi | input | 1 | Clear-enable command strobe |
| cmd_wr_array | input | 1 | Array write request strobe |
| cmd_wr_status | input | 1 | Status write request strobe |
| addr | input | ADDR_W | Target byte address of an array write |
| new_bp | input | 2 | Protect code carried by a status write |
| wp_n | input | 1 | Hardware write-protect, active low |
| cell_busy | input | 1 | High while the cell is programming |
| wr_grant | output | 1 | Write may proceed; held until busy is seen |
| status | output | 8 | Live status byte |

## Verification
The bench builds the block with the default 8-bit address, which gives a 256-byte array. With that width the protect boundaries C0h, 80h and 00h and their neighbours BFh and 7Fh can be addressed directly. Each protect code is therefore checked exactly at its edge. The cell busy signal is driven by hand. This lets the bench lower `wp_n` and issue commands in the middle of `ST_BURN`, and hold that state for several cycles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_BURN = 2'd2
    } wpc_state_e;

    localparam logic [1:0] BP_RESET = 2'b01;
    localparam int         BP_CODES = 4;

endpackage

// File: rtl/wpc_zone.sv
module wpc_zone #(
    parameter int ADDR_W = 8
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import wpc_pkg::*;

    localparam int LW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [BP_CODES-1:0] code_hit;
    logic [LW-1:0]       addr_x;

    assign addr_x = {1'b0, addr};

    assign code_hit[0] = 1'b0;

    for (genvar g = 1; g < BP_CODES; g++) begin : g_lim
        localparam int LIM_I = (g == 1) ? DEPTH - DEPTH / 4 :
                               (g == 2) ? DEPTH / 2 : 0;
        localparam logic [LW-1:0] LIM = LW'(LIM_I);
        assign code_hit[g] = (addr_x >= LIM);
    end

    assign hit = code_hit[bp];

endmodule

// File: rtl/wpc_enable.sv
module wpc_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic wp_n,
    input  logic cycle_done,
    output logic wel
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (!wp_n || cycle_done || clr_req) begin
            wel <= 1'b0;
        end else if (set_req) begin
            wel <= 1'b1;
        end
    end

    AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !wel); // R4

    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !wel); // R7

endmodule

// File: rtl/wpc_seq.sv
module wpc_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_status,
    input  logic [1:0] new_bp,
    input  logic       busy,
    output logic       grant,
    output logic       wip,
    output logic       done,
    output logic [1:0] bp
);
    import wpc_pkg::*;

    wpc_state_e state_q, state_d;
    logic       pend_sts_q;
    logic [1:0] pend_bp_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ARM;
            ST_ARM:  if (busy)  state_d = ST_BURN;
            ST_BURN: if (!busy) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant = 1'b0;
        wip   = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: wip   = 1'b0;
            ST_ARM:  grant = 1'b1;
            ST_BURN: done  = !busy;
            default: wip   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sts_q <= 1'b0;
            pend_bp_q  <= 2'b00;
            bp         <= BP_RESET;
        end else begin
            if (state_q == ST_IDLE && start) begin
                pend_sts_q <= is_status;
                pend_bp_q  <= new_bp;
            end
            if (done && pend_sts_q) bp <= pend_bp_q;
        end
    end

    AST_GRANT_IMPLIES_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> wip); // R6

    AST_BP_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(bp)); // R9

    AST_BURN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURN && busy) |=> wip); // R8

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wr_array,
    input  logic              cmd_wr_status,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        new_bp,
    input  logic              wp_n,
    input  logic              cell_busy,
    output logic              wr_grant,
    output logic [7:0]        status
);

    logic       wip, wel, done, hit, start, idle;
    logic [1:0] bp;

    assign idle  = !wip;
    assign start = idle && wp_n && wel &&
                   (cmd_wr_status || (cmd_wr_array && !hit));

    wpc_zone #(.ADDR_W(ADDR_W)) u_zone (
        .bp   (bp),
        .addr (addr),
        .hit  (hit)
    );

    wpc_enable u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (idle && cmd_wren),
        .clr_req    (idle && cmd_wrdi),
        .wp_n       (wp_n),
        .cycle_done (done),
        .wel        (wel)
    );

    wpc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_status (cmd_wr_status),
        .new_bp    (new_bp),
        .busy      (cell_busy),
        .grant     (wr_grant),
        .wip       (wip),
        .done      (done),
        .bp        (bp)
    );

    assign status = {4'b0000, bp, wel, wip};

    AST_GUARDED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wr_array && !cmd_wr_status && hit) |=> !wr_grant); // R3

    AST_NO_LATCH_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !wel) |=> !wr_grant); // R5

    AST_WP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !wp_n) |=> !wr_grant); // R4

    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !wr_grant) |=> !wr_grant); // R9

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel); // R7

endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;

    localparam int K_WREN = 0, K_WRDI = 1, K_ARR = 2, K_STS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wren = 0, cmd_wrdi = 0, cmd_wr_array = 0, cmd_wr_status = 0;
    logic [7:0] addr = 0;
    logic [1:0] new_bp = 0;
    logic       wp_n = 1'b1;
    logic       cell_busy = 1'b0;
    logic       wr_grant;
    logic [7:0] status;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wp_guard #(.ADDR_W(8)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wren      (cmd_wren),
        .cmd_wrdi      (cmd_wrdi),
        .cmd_wr_array  (cmd_wr_array),
        .cmd_wr_status (cmd_wr_status),
        .addr          (addr),
        .new_bp        (new_bp),
        .wp_n          (wp_n),
        .cell_busy     (cell_busy),
        .wr_grant      (wr_grant),
        .status        (status)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic pulse(input int kind, input logic [7:0] a, input logic [1:0] b);
        @(negedge clk);
        cmd_wren      = (kind == K_WREN);
        cmd_wrdi      = (kind == K_WRDI);
        cmd_wr_array  = (kind == K_ARR);
        cmd_wr_status = (kind == K_STS);
        addr   = a;
        new_bp = b;
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_wr_array = 0; cmd_wr_status = 0;
    endtask

    // cell busy for n cycles, then released; ends one cycle after release
    task automatic run_cell(input int n);
        cell_busy = 1'b1;
        repeat (n) @(negedge clk);
        cell_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R2 status", status, 8'h04);
        chk("R2 grant", {7'b0, wr_grant}, 8'h00);
        chk("R1 upper bits", {status[7:4], 4'h0}, 8'h00);
    endtask

    task automatic t_enable;
        pulse(K_ARR, 8'h10, 2'b00);
        chk("R5 no latch refused", {7'b0, wr_grant}, 8'h00);
        pulse(K_WREN, 8'h00, 2'b00);
        chk("R5 set latch", status, 8'h06);
        pulse(K_WRDI, 8'h00, 2'b00);
        chk("R5 clear latch", status, 8'h04);
    endtask

    task automatic t_array_write;
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_ARR, 8'hC0, 2'b00);
        chk("R3 C0 guarded", {7'b0, wr_grant}, 8'h00);
        chk("R3 latch kept", status, 8'h06);
        pulse(K_ARR, 8'hBF, 2'b00);
        chk("R6 grant", {7'b0, wr_grant}, 8'h01);
        chk("R6 wip set", status, 8'h07);
        cell_busy = 1'b1;
        @(negedge clk);
        chk("R6 grant dropped", {7'b0, wr_grant}, 8'h00);
        chk("R9 status readable", status, 8'h07);
        run_cell(2);
        chk("R7 end clears", status, 8'h04);
    endtask

    task automatic t_wp_midcycle;
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_ARR, 8'h00, 2'b00);
        chk("R6 grant low addr", {7'b0, wr_grant}, 8'h01);
        cell_busy = 1'b1;
        @(negedge clk);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R8 wip kept, latch cleared", status, 8'h05);
        repeat (2) @(negedge clk);
        chk("R8 still running", status, 8'h05);
        cell_busy = 1'b0;
        @(negedge clk);
        chk("R8 finished", status, 8'h04);
        wp_n = 1'b1;
    endtask

    task automatic t_wp_block;
        wp_n = 1'b0;
        pulse(K_WREN, 8'h00, 2'b00);
        chk("R4 set blocked", status, 8'h04);
        wp_n = 1'b1;
        pulse(K_WREN, 8'h00, 2'b00);
        chk("R4 set with pin high", status, 8'h06);
        wp_n = 1'b0;
        @(negedge clk);
        chk("R4 pin clears latch", status, 8'h04);
        pulse(K_STS, 8'h00, 2'b00);
        chk("R4 status write refused", {7'b0, wr_grant}, 8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_protect_codes;
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_STS, 8'h00, 2'b00);
        chk("R3 status write ok", {7'b0, wr_grant}, 8'h01);
        run_cell(2);
        chk("R7 bp 00", status, 8'h00);
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_ARR, 8'hFF, 2'b00);
        chk("R3 FF open at 00", {7'b0, wr_grant}, 8'h01);
        run_cell(1);
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_STS, 8'h00, 2'b10);
        run_cell(1);
        chk("R7 bp 10", status, 8'h08);
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_ARR, 8'h80, 2'b00);
        chk("R3 80 guarded at 10", {7'b0, wr_grant}, 8'h00);
        pulse(K_ARR, 8'h7F, 2'b00);
        chk("R3 7F open at 10", {7'b0, wr_grant}, 8'h01);
        run_cell(1);
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_STS, 8'h00, 2'b11);
        run_cell(1);
        chk("R7 bp 11", status, 8'h0C);
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_ARR, 8'h00, 2'b00);
        chk("R3 00 guarded at 11", {7'b0, wr_grant}, 8'h00);
        pulse(K_STS, 8'h00, 2'b01);
        chk("R3 status write at 11", {7'b0, wr_grant}, 8'h01);
        run_cell(1);
        chk("R7 bp back to 01", status, 8'h04);
    endtask

    task automatic t_busy_ignore;
        pulse(K_WREN, 8'h00, 2'b00);
        pulse(K_STS, 8'h00, 2'b00);
        cell_busy = 1'b1;
        pulse(K_WRDI, 8'h00, 2'b00);
        chk("R9 clear ignored", status, 8'h07);
        pulse(K_STS, 8'h00, 2'b11);
        chk("R9 no regrant", {7'b0, wr_grant}, 8'h00);
        pulse(K_ARR, 8'h00, 2'b00);
        chk("R9 no array grant", {7'b0, wr_grant}, 8'h00);
        cell_busy = 1'b0;
        @(negedge clk);
        chk("R9 first bp kept", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_array_write();
        t_wp_midcycle();
        t_wp_block();
        t_protect_codes();
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule